// File: doc/BRIEF.md
# DMA Channel Sequencing and Completion Logic

This block is the control side of a single DMA channel. Software programs a transfer count and a control word over a simple register bus, and the block decides, cycle by cycle, whether the channel may issue its next transfer. It issues each transfer as a one-cycle grant to the data mover and waits for a read-complete handshake before it issues another. It counts transfers down and raises a done flag when the final transfer is issued. If interrupts are enabled, it raises an interrupt once that final transfer's read has completed.

Transfers run only when the channel enable and the global master enable are both 1 and nothing blocks them. A transfer is blocked by the done flag, a global NMI fault or a global address fault. In auto mode a transfer is issued as soon as it is permitted. In external mode each transfer also waits for the request input. Clearing an enable or raising a fault stops the channel and leaves the done flag at 0. Software clears the done flag in two steps: it reads the control register and sees the flag as 1, then it writes 0 to the flag bit.

The sequencer has four states. ST_IDLE means no transfer is permitted. ST_ARMED means a transfer is permitted and the channel waits for a request. ST_ISSUE is the one cycle in which the grant is driven. ST_WAIT_RD waits for the read-complete handshake. The transitions are:
- IDLE→ARMED when a transfer is permitted.
- ARMED→IDLE when permission is lost.
- ARMED→ISSUE when the request condition is met.
- ISSUE→WAIT_RD always.
- WAIT_RD→ARMED on the handshake if a transfer is still permitted, and WAIT_RD→IDLE on the handshake otherwise.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the channel enable, interrupt enable, done flag and count are all 0, and the grant and interrupt outputs are low.
- R2: The control register is at address 0, with bit 0 the channel enable, bit 1 the done flag and bit 2 the interrupt enable. The count register is at address 1 and reads back its current value. Other bits read as 0.
- R3: In auto mode (mode_ext=0) transfers are granted without any request once the channel enable and glb_enable are both 1 and the done flag, glb_nmi_fault and glb_addr_fault are all 0.
- R4: In external mode (mode_ext=1) a transfer is granted only while ext_req is 1, in addition to the conditions of R3.
- R5: Each grant lasts exactly one cycle, and no further grant is issued until rd_done has been seen for the previous transfer.
- R6: The count decrements by 1 on each grant. Writing 0 to the count register means 2^COUNT_W transfers, so the first grant leaves 2^COUNT_W-1.
- R7: The done flag sets in the cycle after the grant that takes the count from 1 to 0, which is when the final transfer starts. It does not wait for that transfer to finish.
- R8: Clearing the channel enable or glb_enable, or raising either fault, stops all further grants, and the done flag stays 0.
- R9: While the done flag is 1 no grant is issued, even with the channel enable set.
- R10: A write of 0 to control bit 1 clears the done flag only if a control read has returned the flag as 1 and no later control read has returned it as 0. A write of 1 to bit 1 never changes the flag.
- R11: irq_out is high only when the interrupt enable is 1, the done flag is 1 and rd_done has arrived for the final transfer. It drops in the cycle after the flag is cleared or the interrupt enable is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from bus_addr) |
| glb_enable | input | 1 | Global master enable |
| glb_nmi_fault | input | 1 | Global NMI fault flag |
| glb_addr_fault | input | 1 | Global address-error flag |
| mode_ext | input | 1 | 0 = auto request, 1 = external request |
| ext_req | input | 1 | External transfer request |
| rd_done | input | 1 | Read cycle of the current transfer has ended |
| xfer_grant | output | 1 | One-cycle grant per transfer |
| irq_out | output | 1 | End-of-transfer interrupt |

## Verification
Several properties are checked on every cycle:
- each grant lasts exactly one cycle;
- only one transfer is outstanding at a time;
- no grant follows a cycle in which the done flag, a fault or a cleared enable blocked the channel;
- the count drops by one per grant;
- the done flag rises only right after a grant;
- a write of 1 leaves the flag set;
- the interrupt falls with the flag.

Other behaviour only the directed scenarios can show. These are the two-step clear depending on whether the flag was read first, the flag staying at 0 after aborts, the wrap of a zero count to its maximum, the external request gating, and the interrupt waiting for the final read.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_ISSUE   = 2'd2,
        ST_WAIT_RD = 2'd3
    } seq_state_e;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_DONE_BIT = 1;
    localparam int unsigned CTRL_IE_BIT   = 2;
    localparam int unsigned CTRL_BITS     = 3;

    localparam int unsigned REG_CTRL_ADDR  = 0;
    localparam int unsigned REG_COUNT_ADDR = 1;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned COUNT_W = 16,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               issue,
    output logic               chan_en,
    output logic               irq_en,
    output logic               done_flag,
    output logic [COUNT_W-1:0] count_q
);

    localparam logic [ADDR_W-1:0]  CTRL_A  = ADDR_W'(REG_CTRL_ADDR);
    localparam logic [ADDR_W-1:0]  COUNT_A = ADDR_W'(REG_COUNT_ADDR);
    localparam logic [COUNT_W-1:0] ONE     = COUNT_W'(1);

    logic sel_ctrl, sel_count;
    logic wr_ctrl, rd_ctrl, wr_count;
    logic clr_armed;
    logic done_clear, final_issue;
    logic unused_wdata_hi;

    assign sel_ctrl    = (bus_addr == CTRL_A);
    assign sel_count   = (bus_addr == COUNT_A);
    assign wr_ctrl     = bus_wr & sel_ctrl;
    assign rd_ctrl     = bus_rd & sel_ctrl;
    assign wr_count    = bus_wr & sel_count;
    assign done_clear  = wr_ctrl & ~bus_wdata[CTRL_DONE_BIT] & clr_armed & done_flag;
    assign final_issue = issue & (count_q == ONE);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:COUNT_W];

    // Control bits written directly by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_en <= 1'b0;
            irq_en  <= 1'b0;
        end else if (wr_ctrl) begin
            chan_en <= bus_wdata[CTRL_EN_BIT];
            irq_en  <= bus_wdata[CTRL_IE_BIT];
        end
    end

    // Clear arm: a control read captures whether the flag was seen as 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_armed <= 1'b0;
        end else if (rd_ctrl) begin
            clr_armed <= done_flag;
        end else if (done_clear) begin
            clr_armed <= 1'b0;
        end
    end

    // Done flag: set at the start of the final transfer, cleared by the two-step sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (final_issue) begin
            done_flag <= 1'b1;
        end else if (done_clear) begin
            done_flag <= 1'b0;
        end
    end

    // Transfer counter: a load takes priority over the decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= bus_wdata[COUNT_W-1:0];
        end else if (issue) begin
            count_q <= count_q - ONE;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CTRL_EN_BIT]   = chan_en;
            bus_rdata[CTRL_DONE_BIT] = done_flag;
            bus_rdata[CTRL_IE_BIT]   = irq_en;
        end else if (sel_count) begin
            bus_rdata[COUNT_W-1:0] = count_q;
        end
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic glb_enable,
    input  logic done_flag,
    input  logic nmi_fault,
    input  logic addr_fault,
    input  logic mode_ext,
    input  logic ext_req,
    input  logic rd_done,
    output logic grant,
    output logic waiting_rd
);

    seq_state_e state_q, state_d;
    logic permit, req_ok;

    assign permit = chan_en & glb_enable & ~done_flag & ~nmi_fault & ~addr_fault;
    assign req_ok = ~mode_ext | ext_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (permit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!permit)     state_d = ST_IDLE;
                else if (req_ok) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_d = ST_WAIT_RD;
            end
            ST_WAIT_RD: begin
                if (rd_done) state_d = permit ? ST_ARMED : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant      = 1'b0;
        waiting_rd = 1'b0;
        unique case (state_q)
            ST_ISSUE:   grant      = 1'b1;
            ST_WAIT_RD: waiting_rd = 1'b1;
            default: begin
                grant      = 1'b0;
                waiting_rd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_flag,
    input  logic irq_en,
    input  logic waiting_rd,
    input  logic rd_done,
    output logic irq_out
);

    logic final_read_seen;

    // Records that the read of the final transfer has ended; forgotten with the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            final_read_seen <= 1'b0;
        end else if (!done_flag) begin
            final_read_seen <= 1'b0;
        end else if (waiting_rd && rd_done) begin
            final_read_seen <= 1'b1;
        end
    end

    assign irq_out = final_read_seen & done_flag & irq_en;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned COUNT_W = 16,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              glb_enable,
    input  logic              glb_nmi_fault,
    input  logic              glb_addr_fault,
    input  logic              mode_ext,
    input  logic              ext_req,
    input  logic              rd_done,
    output logic              xfer_grant,
    output logic              irq_out
);

    logic               chan_en, irq_en, done_flag, waiting_rd;
    logic [COUNT_W-1:0] count_q;

    dma_chan_regs #(
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .issue     (xfer_grant),
        .chan_en   (chan_en),
        .irq_en    (irq_en),
        .done_flag (done_flag),
        .count_q   (count_q)
    );

    dma_chan_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .glb_enable (glb_enable),
        .done_flag  (done_flag),
        .nmi_fault  (glb_nmi_fault),
        .addr_fault (glb_addr_fault),
        .mode_ext   (mode_ext),
        .ext_req    (ext_req),
        .rd_done    (rd_done),
        .grant      (xfer_grant),
        .waiting_rd (waiting_rd)
    );

    dma_chan_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_flag  (done_flag),
        .irq_en     (irq_en),
        .waiting_rd (waiting_rd),
        .rd_done    (rd_done),
        .irq_out    (irq_out)
    );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned COUNT_W = 16,
    parameter int unsigned ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               glb_enable,
    input logic               glb_nmi_fault,
    input logic               glb_addr_fault,
    input logic               rd_done,
    input logic               xfer_grant,
    input logic               irq_out,
    input logic               chan_en,
    input logic               done_flag,
    input logic [COUNT_W-1:0] count_q
);

    logic outstanding;
    logic ctrl_wr_one, count_wr;

    assign ctrl_wr_one = bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[1];
    assign count_wr    = bus_wr && (bus_addr == ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (xfer_grant) outstanding <= 1'b1;
        else if (rd_done)    outstanding <= 1'b0;
    end

    a_r5_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_grant |=> !xfer_grant);

    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_grant |-> !outstanding);

    a_r9_no_grant_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_grant |-> !$past(done_flag));

    a_r8_no_grant_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_grant |-> $past(chan_en && glb_enable && !glb_nmi_fault && !glb_addr_fault));

    a_r6_count_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_grant && !count_wr) |=> (count_q == COUNT_W'($past(count_q) - COUNT_W'(1))));

    a_r7_flag_rises_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(xfer_grant));

    a_r10_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && ctrl_wr_one) |=> done_flag);

    a_r11_irq_drops_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> !irq_out);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(
    .DATA_W  (DATA_W),
    .COUNT_W (COUNT_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .glb_enable     (glb_enable),
    .glb_nmi_fault  (glb_nmi_fault),
    .glb_addr_fault (glb_addr_fault),
    .rd_done        (rd_done),
    .xfer_grant     (xfer_grant),
    .irq_out        (irq_out),
    .chan_en        (chan_en),
    .done_flag      (done_flag),
    .count_q        (count_q)
);

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;

    localparam int DW = 32;
    localparam int CW = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          glb_enable = 1'b0, glb_nmi_fault = 1'b0, glb_addr_fault = 1'b0;
    logic          mode_ext = 1'b0, ext_req = 1'b0, rd_done = 1'b0;
    logic          xfer_grant, irq_out;

    int checks = 0;
    int fails  = 0;
    int gcnt   = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    dma_chan_ctrl #(.DATA_W(DW), .COUNT_W(CW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glb_enable(glb_enable), .glb_nmi_fault(glb_nmi_fault),
        .glb_addr_fault(glb_addr_fault), .mode_ext(mode_ext), .ext_req(ext_req),
        .rd_done(rd_done), .xfer_grant(xfer_grant), .irq_out(irq_out)
    );

    always @(negedge clk) if (rst_n && xfer_grant) gcnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {bus_wr, bus_rd, glb_enable, glb_nmi_fault, glb_addr_fault} = '0;
        {mode_ext, ext_req, rd_done} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        gcnt = 0;
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Answers n grants with rd_done; the last one is left open when last_done is 0
    task automatic serve(input int n, input bit last_done, output int got);
        got = 0;
        for (int i = 0; i < n; i++) begin
            int t = 0;
            while (!xfer_grant && t < 60) begin @(negedge clk); t++; end
            if (!xfer_grant) break;
            got++;
            @(negedge clk);
            if (i < n-1 || last_done) begin
                @(negedge clk);
                rd_done = 1'b1;
                @(negedge clk);
                rd_done = 1'b0;
            end
        end
    endtask

    // rd_done and a register write in the same cycle
    task automatic done_and_write(input int a, input logic [31:0] d);
        rd_done = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        rd_done = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        chk("R1 grant", 32'(xfer_grant), 0);
        chk("R1 irq", 32'(irq_out), 0);
        bus_read(0, v); chk("R1 ctrl", v, 0);
        bus_read(1, v); chk("R1 count", v, 0);
        bus_write(1, 32'hABC3); bus_read(1, v); chk("R2 count readback", v, 32'hABC3);
        bus_write(0, 32'h4); bus_read(0, v); chk("R2 ie bit2", v, 32'h4);
        bus_read(2, v); chk("R2 unused addr", v, 0);
    endtask

    task automatic t_auto_irq();
        logic [31:0] v; int got; int g0;
        do_reset();
        glb_enable = 1'b1;
        bus_write(1, 3);
        bus_write(0, 32'h5);
        serve(2, 1'b1, got);
        chk("R3 auto grants", got, 2);
        chk("R5 one grant per handshake", gcnt, 2);
        serve(1, 1'b0, got);
        bus_read(1, v); chk("R6 count at final", v, 0);
        bus_read(0, v); chk("R7 flag set at final issue", v, 32'h7);
        chk("R11 irq waits for final read", 32'(irq_out), 0);
        rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
        chk("R11 irq after final read", 32'(irq_out), 1);
        g0 = gcnt;
        repeat (20) @(negedge clk);
        chk("R9 no grant while flag set", gcnt, g0);
        bus_write(0, 32'h3);
        chk("R11 irq drops on ie=0", 32'(irq_out), 0);
        bus_read(0, v); chk("R10 write one keeps flag", v, 32'h3);
        repeat (10) @(negedge clk);
        chk("R9 en with flag set grants nothing", gcnt, g0);
        bus_write(0, 32'h6);
        chk("R11 irq back with ie=1", 32'(irq_out), 1);
        bus_read(0, v);
        bus_write(0, 32'h4);
        chk("R11 irq drops on flag clear", 32'(irq_out), 0);
        bus_read(0, v); chk("R10 armed clear", v, 32'h4);
    endtask

    task automatic t_external();
        logic [31:0] v; int got; int g0;
        do_reset();
        glb_enable = 1'b1; mode_ext = 1'b1;
        bus_write(1, 2);
        bus_write(0, 32'h1);
        g0 = gcnt;
        repeat (15) @(negedge clk);
        chk("R4 no grant without request", gcnt, g0);
        ext_req = 1'b1;
        serve(2, 1'b1, got);
        chk("R4 grants with request", got, 2);
        ext_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 no irq with ie=0", 32'(irq_out), 0);
        bus_write(0, 32'h0);
        bus_read(0, v); chk("R10 unarmed write zero ignored", v, 32'h2);
        bus_write(0, 32'h0);
        bus_read(0, v); chk("R10 clear after read", v, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v; int got; int g0;
        do_reset();
        glb_enable = 1'b1;
        bus_write(1, 5);
        bus_write(0, 32'h1);
        serve(2, 1'b0, got);
        done_and_write(0, 32'h0);
        g0 = gcnt;
        repeat (20) @(negedge clk);
        chk("R8 enable clear stops grants", gcnt, g0);
        bus_read(0, v); chk("R8 flag stays 0 after abort", v, 0);
        bus_read(1, v); chk("R6 count after two", v, 3);
        bus_write(0, 32'h1);
        serve(1, 1'b1, got);
        glb_enable = 1'b0;
        g0 = gcnt;
        repeat (20) @(negedge clk);
        chk("R8 master enable stops grants", gcnt, g0);
        bus_read(0, v); chk("R8 flag 0 after master stop", v, 32'h1);
        bus_read(1, v); chk("R6 count after three", v, 2);
    endtask

    task automatic t_faults();
        logic [31:0] v; int got; int g0;
        do_reset();
        glb_enable = 1'b1; glb_nmi_fault = 1'b1;
        bus_write(1, 2);
        bus_write(0, 32'h1);
        repeat (15) @(negedge clk);
        chk("R8 nmi blocks", gcnt, 0);
        glb_nmi_fault = 1'b0;
        serve(1, 1'b1, got);
        glb_addr_fault = 1'b1;
        g0 = gcnt;
        repeat (15) @(negedge clk);
        chk("R8 address fault blocks", gcnt, g0);
        bus_read(0, v); chk("R8 flag 0 after fault", v, 32'h1);
        glb_addr_fault = 1'b0;
        serve(1, 1'b1, got);
        chk("R3 resumes after fault", got, 1);
        bus_read(0, v); chk("R7 flag after last", v, 32'h3);
    endtask

    task automatic t_max_and_outstanding();
        logic [31:0] v; int got;
        do_reset();
        glb_enable = 1'b1;
        bus_write(1, 0);
        bus_write(0, 32'h1);
        serve(1, 1'b0, got);
        repeat (15) @(negedge clk);
        chk("R5 single grant while read open", gcnt, 1);
        done_and_write(0, 32'h0);
        bus_read(1, v); chk("R6 zero count wraps to max", v, 32'hFFFF);
        bus_read(0, v); chk("R7 no flag at max-1", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_auto_irq();
        t_external();
        t_abort();
        t_faults();
        t_max_and_outstanding();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule